// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that completes one instruction on every clock edge. Each cycle it takes an instruction word from its own instruction store at the current program counter and decodes it. It reads two source registers and computes with a three-function ALU. When the instruction calls for it, it reads or writes its own data store. It then writes back a result and moves the program counter on. It handles seven instructions: register add, subtract and signed set-on-less-than, word load, word store, branch-if-equal and an unconditional jump. Any other encoding behaves as a no-operation.

A preload port lets the environment fill either memory one word at a time. While that port is active the core is frozen, so programs and data can be loaded during reset or between instructions. Two debug outputs expose the program counter and any one register, chosen by a debug address, so a harness can follow execution without any other access.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes `START_ADDR` (default 0) and every register reads back as zero afterwards.
- R2: In each running cycle, one instruction is fetched from instruction word `pc[9:2]`. Unless a taken branch or a jump applies, the program counter advances by 4.
- R3: Opcode bits [31:26] = 000000 selects register arithmetic, with source fields [25:21] and [20:16] and destination [15:11]. Function bits [5:0] = 100000 adds, 100010 subtracts (first minus second), and 101010 writes 1 when the first source is less than the second as signed values, and 0 otherwise.
- R4: Opcode 100011 loads and 101011 stores. The byte address is the register in [25:21] plus the sign-extended immediate [15:0], and it selects data word `addr[9:2]`. A load writes that word into the register named by [20:16]. A store writes that register to memory and changes no register.
- R5: Opcode 000100 compares the registers in [25:21] and [20:16]. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise it is PC+4.
- R6: Opcode 000010 jumps to a target made of PC+4 bits [31:28], then instruction bits [25:0], then two zero bits.
- R7: Any other opcode, and any function code under opcode 000000 other than the three listed, writes neither a register nor memory, and the PC advances by 4.
- R8: Register 0 always reads as zero, and writes addressed to it are discarded.
- R9: With `load_en` high, `load_data` is written at the next rising edge to word `load_addr` of the instruction store (`load_sel`=0) or the data store (`load_sel`=1). In that cycle the core executes nothing and the PC holds its value.
- R10: `dbg_reg_data` presents, within the same cycle, the register selected by `dbg_reg_addr`, and `dbg_pc` presents the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe; freezes execution |
| load_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr | input | 8 | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_reg_addr | input | 5 | Register selected for debug readout |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
The hardest situation to reach from the ports is a preload that lands while a program is already running. That write must freeze the PC for exactly that cycle, and the data it writes must be visible to a later load. The stimulus reaches it by injecting a data-store write a few instructions into the run, at a word that the program only reads after a jump. A taken branch that skips two instructions, a branch that is not taken, and two unsupported encodings sit on the same path. A register write aimed at register 0 and a negative load/store offset are also on that path, so each leaves a trace in the register values or the PC sequence.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam logic [5:0] OPC_ARITH = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    mem_to_reg;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/scpu_ctrl.sv
module scpu_ctrl
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_fn = ALU_ADD;
    unique case (opcode)
      OPC_ARITH: begin
        ctrl.dst_is_rd = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_ADD; end
          FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SUB; end
          FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SLT; end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_fn = ALU_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic [AW-1:0]   ra_dbg,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_dbg
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          MEM_AW     = 8,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_sel,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  input  logic [4:0]        dbg_reg_addr,
  output logic [XLEN-1:0]   dbg_pc,
  output logic [XLEN-1:0]   dbg_reg_data
);
  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int IMM_W     = 16;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc, pc_plus4, br_target, jmp_target, next_pc;
  logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_y, mem_word, wb_data;
  logic [4:0]      wr_reg;
  logic            run, zero, reg_we_q, dmem_we_q;
  ctrl_t           ctrl;

  assign run = !rst && !load_en;

  // fetch
  assign instr = imem[pc[MEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (load_en && !load_sel) imem[load_addr] <= load_data;
  end

  // decode and operands
  scpu_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign imm_ext  = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign wr_reg   = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign reg_we_q = run && ctrl.reg_we;

  scpu_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we_q),
    .waddr  (wr_reg),
    .wdata  (wb_data),
    .ra_a   (instr[25:21]),
    .ra_b   (instr[20:16]),
    .ra_dbg (dbg_reg_addr),
    .rd_a   (rs_data),
    .rd_b   (rt_data),
    .rd_dbg (dbg_reg_data)
  );

  // execute
  assign alu_b = ctrl.use_imm ? imm_ext : rt_data;

  scpu_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .fn   (ctrl.alu_fn),
    .y    (alu_y),
    .zero (zero)
  );

  // data memory
  assign dmem_we_q = run && ctrl.mem_we;
  assign mem_word  = dmem[alu_y[MEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (load_en && load_sel)  dmem[load_addr] <= load_data;
    else if (dmem_we_q)       dmem[alu_y[MEM_AW+1:2]] <= rt_data;
  end

  assign wb_data = ctrl.mem_to_reg ? mem_word : alu_y;

  // next program counter
  assign pc_plus4   = pc + XLEN'(4);
  assign br_target  = pc_plus4 + (imm_ext << 2);
  assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                next_pc = jmp_target;
    else if (ctrl.branch && zero) next_pc = br_target;
    else                          next_pc = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst)      pc <= START_ADDR;
    else if (run) pc <= next_pc;
  end

  assign dbg_pc = pc;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc[1:0], alu_y[XLEN-1:MEM_AW+2], alu_y[1:0]};
endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk
  import scpu_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] START_ADDR = 32'h0
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data,
  input logic            reg_we,
  input logic            dmem_we
);
  logic [5:0]      op;
  logic [XLEN-1:0] seq_pc, beq_pc, j_pc;
  logic            known_op, equal;

  assign op       = instr[31:26];
  assign seq_pc   = pc + XLEN'(4);
  assign beq_pc   = seq_pc + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign j_pc     = {seq_pc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign equal    = (rs_data == rt_data);
  assign known_op = (op == OPC_ARITH) || (op == OPC_LOAD) || (op == OPC_STORE) ||
                    (op == OPC_BEQ) || (op == OPC_JUMP);

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == START_ADDR));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (run && op != OPC_JUMP && !(op == OPC_BEQ && equal)) |=> (pc == $past(seq_pc)));

  a_r4_store_no_reg: assert property (@(posedge clk) disable iff (rst)
    (run && op == OPC_STORE) |-> !reg_we);

  a_r5_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (run && op == OPC_BEQ && equal) |=> (pc == $past(beq_pc)));

  a_r6_jump: assert property (@(posedge clk) disable iff (rst)
    (run && op == OPC_JUMP) |=> (pc == $past(j_pc)));

  a_r7_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (run && !known_op) |-> (!reg_we && !dmem_we));

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_data == '0));

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc));
endmodule

bind scpu_core scpu_core_chk #(.XLEN(XLEN), .START_ADDR(START_ADDR)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .pc      (pc),
  .instr   (instr),
  .rs_data (rs_data),
  .rt_data (rt_data),
  .reg_we  (reg_we_q),
  .dmem_we (dmem_we_q)
);

// File: tb/scpu_core_test.sv
module scpu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_sel = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  dbg_reg_addr = '0;
  logic [31:0] dbg_pc, dbg_reg_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_reg  [32];
  logic [31:0] m_imem [256];
  logic [31:0] m_dmem [256];
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  scpu_core uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data), .dbg_reg_addr(dbg_reg_addr),
    .dbg_pc(dbg_pc), .dbg_reg_data(dbg_reg_data)
  );

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic model_step();
    logic [31:0] i, a, b, nxt, sx, adr;
    i   = m_imem[m_pc[9:2]];
    a   = m_reg[i[25:21]];
    b   = m_reg[i[20:16]];
    sx  = {{16{i[15]}}, i[15:0]};
    nxt = m_pc + 4;
    adr = a + sx;
    case (i[31:26])
      6'h00: case (i[5:0])
        6'h20: if (i[15:11] != 0) m_reg[i[15:11]] = a + b;
        6'h22: if (i[15:11] != 0) m_reg[i[15:11]] = a - b;
        6'h2A: if (i[15:11] != 0) m_reg[i[15:11]] = ($signed(a) < $signed(b)) ? 1 : 0;
        default: ;
      endcase
      6'h23: if (i[20:16] != 0) m_reg[i[20:16]] = m_dmem[adr[9:2]];
      6'h2B: m_dmem[adr[9:2]] = b;
      6'h04: if (a == b) nxt = m_pc + 4 + (sx << 2);
      6'h02: nxt = {nxt[31:28], i[25:0], 2'b00};
      default: ;
    endcase
    m_pc = nxt;
  endtask

  // one clock: reference updates at the edge, comparisons at the falling edge
  task automatic tick();
    @(posedge clk);
    cyc++;
    if (load_en) begin
      if (load_sel) m_dmem[load_addr] = load_data;
      else          m_imem[load_addr] = load_data;
    end
    if (rst) begin
      m_pc = 32'h0;
      for (int k = 0; k < 32; k++) m_reg[k] = '0;
    end else if (!load_en) begin
      model_step();
    end
    @(negedge clk);
    check(tag, dbg_pc, m_pc);
    dbg_reg_addr = 5'(cyc);
    #1;
    check("R10", dbg_reg_data, m_reg[5'(cyc)]);
  endtask

  task automatic put(input logic sel, input int adr, input logic [31:0] d);
    load_en = 1'b1; load_sel = sel; load_addr = 8'(adr); load_data = d;
    tick();
    load_en = 1'b0;
  endtask

  task automatic expect_reg(input string t, input int r, input logic [31:0] v);
    dbg_reg_addr = 5'(r);
    #1;
    check(t, dbg_reg_data, v);
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prog [23];
    logic [31:0] held_pc;
    for (int k = 0; k < 256; k++) begin m_imem[k] = '0; m_dmem[k] = '0; end
    for (int k = 0; k < 32; k++) m_reg[k] = '0;
    m_pc = '0;

    prog[0]  = enc_i(6'h23, 0, 1, 0);          // lw r1,0(r0)
    prog[1]  = enc_i(6'h23, 0, 2, 4);          // lw r2,4(r0)
    prog[2]  = enc_r(1, 2, 3, 6'h20);          // add r3 = 2
    prog[3]  = enc_r(2, 1, 4, 6'h22);          // sub r4 = -8
    prog[4]  = enc_r(4, 1, 5, 6'h2A);          // slt r5 = 1
    prog[5]  = enc_r(1, 4, 6, 6'h2A);          // slt r6 = 0
    prog[6]  = enc_r(1, 1, 0, 6'h20);          // add into r0
    prog[7]  = enc_i(6'h2B, 0, 3, 12);         // sw r3,12(r0)
    prog[8]  = enc_i(6'h23, 1, 7, 7);          // lw r7,7(r1)
    prog[9]  = enc_i(6'h2B, 1, 4, -1);         // sw r4,-1(r1)
    prog[10] = enc_i(6'h23, 0, 9, 4);          // lw r9,4(r0)
    prog[11] = enc_i(6'h04, 3, 7, 2);          // beq taken -> 0x38
    prog[12] = enc_r(1, 1, 10, 6'h20);         // skipped
    prog[13] = enc_r(1, 1, 11, 6'h20);         // skipped
    prog[14] = enc_i(6'h04, 1, 2, 5);          // beq not taken
    prog[15] = 32'hFC0F_0001;                  // unknown opcode
    prog[16] = enc_r(1, 1, 12, 6'h00);         // unknown funct
    prog[17] = {6'b000010, 26'h15};            // j 0x54
    prog[18] = enc_r(1, 1, 13, 6'h20);         // skipped
    prog[19] = 32'h0;
    prog[20] = 32'h0;
    prog[21] = enc_i(6'h23, 0, 14, 80);        // lw r14,80(r0)
    prog[22] = enc_i(6'h04, 0, 0, -1);         // spin here

    // reset state and preload during reset
    tag = "R1";
    tick();
    check("R1", dbg_pc, 32'h0);
    expect_reg("R1", 5, 32'h0);
    for (int k = 0; k < 23; k++) put(1'b0, k, prog[k]);
    put(1'b1, 0, 32'd5);
    put(1'b1, 1, 32'hFFFF_FFFD);

    // run; inject a data word mid-run
    @(negedge clk);
    rst = 1'b0;
    tag = "R2";
    for (int k = 0; k < 3; k++) tick();
    held_pc = dbg_pc;
    tag = "R9";
    put(1'b1, 20, 32'h0000_1234);
    check("R9", dbg_pc, held_pc);
    tag = "R2";
    for (int k = 0; k < 30; k++) tick();

    check("R5", dbg_pc, 32'h58);
    expect_reg("R3", 3, 32'd2);
    expect_reg("R3", 4, 32'hFFFF_FFF8);
    expect_reg("R3", 5, 32'd1);
    expect_reg("R3", 6, 32'd0);
    expect_reg("R8", 0, 32'd0);
    expect_reg("R4", 7, 32'd2);
    expect_reg("R4", 9, 32'hFFFF_FFF8);
    expect_reg("R5", 10, 32'd0);
    expect_reg("R5", 11, 32'd0);
    expect_reg("R7", 12, 32'd0);
    expect_reg("R6", 13, 32'd0);
    expect_reg("R9", 14, 32'h0000_1234);

    // reset mid-run, then restart
    tag = "R1";
    rst = 1'b1;
    tick();
    check("R1", dbg_pc, 32'h0);
    expect_reg("R1", 14, 32'h0);
    rst = 1'b0;
    tag = "R2";
    for (int k = 0; k < 6; k++) tick();
    expect_reg("R4", 2, 32'hFFFF_FFF8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule